// File: doc/BRIEF.md
# Receive Buffer Scatter with Trailing CRC

This block takes one received frame at a time as a byte stream and spreads it across a chain of receive buffers. Each buffer's capacity comes from a size descriptor offered on a valid/ready channel. The data bytes are written first. The frame's four check bytes, supplied alongside the last data byte, follow them. Every byte leaves as a write strobe that carries an address relative to the start of the current buffer, so an outer engine can add the buffer's base address.

When a buffer stops taking bytes, the block issues a count write-back. That word gives the byte count, a filled flag and, on the buffer that finishes the frame, an end-of-frame flag. After the frame it issues a frame-status word together with a frame event. It then raises a sticky interrupt. The block also tracks whether the receive unit is ready or suspended. Frames that arrive while the unit is suspended, or while the link is down, are drained and leave no trace. A frame descriptor can ask for the unit to suspend once its frame is done.

Top module: `rx_scatter`

## Requirements
- R1: The bytes written for a frame of N data bytes number N+4. The N data bytes come first in arrival order, then the four check bytes, most significant byte first. In every buffer the write address starts at 0 and rises by one per byte.
- R2: A buffer's capacity is bits 13:0 of its size word, and bit 14 of that word is ignored. Each buffer takes the smaller of its capacity and the bytes still owed. Its count write-back carries that byte count in bits 13:0 and has bit 14 (filled) set.
- R3: The count write-back of the buffer that receives the final check byte has bit 15 (end of frame) set, and no other buffer's does. The check bytes may be split across two buffers.
- R4: A size word with bit 15 set marks the last buffer of the chain. If the frame is not complete when that buffer is full, no further descriptor is taken and the remaining input bytes are consumed without writes. The frame status then has bit 13 clear.
- R5: Once a frame is finished, one frame-status word is written. It has bit 15 (complete) set, bit 13 (OK) set only when every byte was stored, and bit 0 equal to the group flag (broadcast or multicast) sampled at the frame's first byte. A frame event pulses in the same cycle.
- R6: The interrupt output rises in the cycle after the status write and stays high until the acknowledge input is seen. If the acknowledge arrives in the same cycle as a status write, the interrupt is set.
- R7: If the receive unit is suspended or the link is down when a frame's first byte is offered, the whole frame is consumed with no byte write, no count write, no descriptor taken and no status.
- R8: If the frame descriptor's suspend flag or end-of-list flag was set at the frame's first byte, the unit becomes suspended after the status write, and a left-active event pulses together with that status write. A start pulse makes the unit ready again. After reset the unit is suspended.
- R9: A size word whose capacity is zero pulses the overflow output. No byte and no count write happens for it. If it also marks the chain end, the rule of R4 applies. Otherwise the next descriptor is requested.
- R10: In and after reset the block takes no byte and no descriptor, writes nothing, and holds the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up_i | input | 1 | Link is up |
| ru_start_i | input | 1 | Pulse: make the receive unit ready |
| irq_ack_i | input | 1 | Clears the interrupt |
| in_valid_i | input | 1 | Frame byte valid |
| in_ready_o | output | 1 | Frame byte taken |
| in_data_i | input | 8 | Frame byte |
| in_last_i | input | 1 | Marks the last data byte of the frame |
| crc_i | input | 32 | Check value, sampled with the last data byte |
| group_i | input | 1 | Frame is broadcast or multicast, sampled at the first byte |
| fd_susp_i | input | 1 | Frame descriptor asks for suspend after this frame |
| fd_eol_i | input | 1 | Frame descriptor is the last of its list |
| bd_valid_i | input | 1 | Buffer size word valid |
| bd_ready_o | output | 1 | Buffer size word taken |
| bd_size_i | input | 16 | Buffer size word: capacity 13:0, chain end 15 |
| wr_en_o | output | 1 | Byte write strobe |
| wr_addr_o | output | 14 | Byte offset inside the current buffer |
| wr_data_o | output | 8 | Byte to write |
| cnt_we_o | output | 1 | Count write-back strobe |
| cnt_word_o | output | 16 | Count word: count 13:0, filled 14, end of frame 15 |
| stat_we_o | output | 1 | Frame-status write strobe |
| stat_word_o | output | 16 | Status word: complete 15, OK 13, group 0 |
| frame_ev_o | output | 1 | Frame-received event pulse |
| rnr_ev_o | output | 1 | Receive unit left active state, pulse |
| ovf_o | output | 1 | Zero-capacity buffer pulse |
| irq_o | output | 1 | Sticky interrupt |

## Verification
The final check byte lands in the same cycle as its buffer's end-of-frame count write-back. When the check bytes straddle a buffer boundary, a filled-only write-back of the first buffer also meets a byte write. Directed frames sized so that the check bytes exactly fill a buffer or split across two provoke both cases, and the bench judges each byte and count word against a reference scatter computed from the size list. The other collision is an interrupt acknowledge held high across a frame's completion. The bench expects the interrupt to read high the cycle after the status write and low one cycle later.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_MOVE,
        ST_DROP,
        ST_DONE
    } rxs_state_e;

    // Per-frame context captured at the first byte and updated during the fill
    typedef struct packed {
        logic group;
        logic stop;
        logic trunc;
        logic in_crc;
        logic keep_stat;
    } rxs_ctx_t;

    localparam int STAT_W        = 16;
    localparam int STAT_DONE_BIT = 15;
    localparam int STAT_OK_BIT   = 13;
    localparam int STAT_GRP_BIT  = 0;

    function automatic logic [STAT_W-1:0] status_word(input logic ok, input logic grp);
        logic [STAT_W-1:0] w;
        w                = '0;
        w[STAT_DONE_BIT] = 1'b1;
        w[STAT_OK_BIT]   = ok;
        w[STAT_GRP_BIT]  = grp;
        return w;
    endfunction

endpackage

// File: rtl/rxs_buf_track.sv
module rxs_buf_track #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] cap_in,
    input  logic             chain_in,
    input  logic             step,
    output logic [CNT_W-1:0] pos,
    output logic             chain,
    output logic             at_full
);
    logic [CNT_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos   <= '0;
            cap_q <= '0;
            chain <= 1'b0;
        end else if (load) begin
            pos   <= '0;
            cap_q <= cap_in;
            chain <= chain_in;
        end else if (step) begin
            pos <= pos + CNT_W'(1);
        end
    end

    // The byte now being written is the last one the buffer can hold
    assign at_full = (pos == cap_q - CNT_W'(1));

endmodule

// File: rtl/rxs_crc_tail.sv
module rxs_crc_tail #(
    parameter int CRC_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [8*CRC_BYTES-1:0] crc_in,
    input  logic                   step,
    output logic [7:0]             byte_o,
    output logic                   final_o
);
    localparam int CW = 8 * CRC_BYTES;
    localparam int IW = (CRC_BYTES > 1) ? $clog2(CRC_BYTES) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(CRC_BYTES - 1);

    logic [CW-1:0] sh_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= crc_in;
            idx_q <= '0;
        end else if (step) begin
            sh_q  <= sh_q << 8;
            idx_q <= idx_q + IW'(1);
        end
    end

    // Most significant byte leaves first
    assign byte_o  = sh_q[CW-1 -: 8];
    assign final_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/rxs_ru_ctl.sv
module rxs_ru_ctl (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic done,
    input  logic ack,
    output logic suspended,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            suspended <= 1'b1;
            irq       <= 1'b0;
        end else begin
            if (stop)       suspended <= 1'b1;
            else if (start) suspended <= 1'b0;

            if (done)     irq <= 1'b1;
            else if (ack) irq <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_scatter.sv
module rx_scatter
    import rxs_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int CRC_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   link_up_i,
    input  logic                   ru_start_i,
    input  logic                   irq_ack_i,
    input  logic                   in_valid_i,
    output logic                   in_ready_o,
    input  logic [7:0]             in_data_i,
    input  logic                   in_last_i,
    input  logic [8*CRC_BYTES-1:0] crc_i,
    input  logic                   group_i,
    input  logic                   fd_susp_i,
    input  logic                   fd_eol_i,
    input  logic                   bd_valid_i,
    output logic                   bd_ready_o,
    input  logic [CNT_W+1:0]       bd_size_i,
    output logic                   wr_en_o,
    output logic [CNT_W-1:0]       wr_addr_o,
    output logic [7:0]             wr_data_o,
    output logic                   cnt_we_o,
    output logic [CNT_W+1:0]       cnt_word_o,
    output logic                   stat_we_o,
    output logic [STAT_W-1:0]      stat_word_o,
    output logic                   frame_ev_o,
    output logic                   rnr_ev_o,
    output logic                   ovf_o,
    output logic                   irq_o
);
    localparam int SZ_W      = CNT_W + 2;
    localparam int CHAIN_BIT = SZ_W - 1;

    rxs_state_e st;
    rxs_ctx_t   ctx;

    logic             ru_susp;
    logic             refuse;
    logic             bd_take;
    logic             cap_zero;
    logic             bd_chain;
    logic             data_phase;
    logic             byte_take;
    logic             crc_take;
    logic             buf_full;
    logic             chain;
    logic [CNT_W-1:0] pos;
    logic [7:0]       crc_byte;
    logic             crc_final;
    logic             frame_end_now;
    logic             unused_fill_bit;

    assign unused_fill_bit = bd_size_i[CNT_W];

    assign refuse     = ru_susp || !link_up_i;
    assign bd_ready_o = (st == ST_DESC);
    assign bd_take    = bd_ready_o && bd_valid_i;
    assign cap_zero   = (bd_size_i[CNT_W-1:0] == '0);
    assign bd_chain   = bd_size_i[CHAIN_BIT];

    assign data_phase = (st == ST_MOVE) && !ctx.in_crc;
    assign in_ready_o = data_phase || (st == ST_DROP);
    assign byte_take  = data_phase && in_valid_i;
    assign crc_take   = (st == ST_MOVE) && ctx.in_crc;

    assign frame_end_now = crc_take && crc_final;

    assign wr_en_o    = byte_take || crc_take;
    assign wr_addr_o  = pos;
    assign wr_data_o  = crc_take ? crc_byte : in_data_i;

    assign cnt_we_o   = wr_en_o && (buf_full || frame_end_now);
    assign cnt_word_o = {frame_end_now, 1'b1, pos + CNT_W'(1)};

    assign ovf_o       = bd_take && cap_zero;
    assign stat_we_o   = (st == ST_DONE);
    assign stat_word_o = status_word(!ctx.trunc, ctx.group);
    assign frame_ev_o  = stat_we_o;
    assign rnr_ev_o    = stat_we_o && ctx.stop;

    rxs_buf_track #(.CNT_W(CNT_W)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .load     (bd_take && !cap_zero),
        .cap_in   (bd_size_i[CNT_W-1:0]),
        .chain_in (bd_chain),
        .step     (wr_en_o),
        .pos      (pos),
        .chain    (chain),
        .at_full  (buf_full)
    );

    rxs_crc_tail #(.CRC_BYTES(CRC_BYTES)) u_crc (
        .clk     (clk),
        .rst     (rst),
        .load    (byte_take && in_last_i),
        .crc_in  (crc_i),
        .step    (crc_take),
        .byte_o  (crc_byte),
        .final_o (crc_final)
    );

    rxs_ru_ctl u_ru (
        .clk       (clk),
        .rst       (rst),
        .start     (ru_start_i),
        .stop      (rnr_ev_o),
        .done      (stat_we_o),
        .ack       (irq_ack_i),
        .suspended (ru_susp),
        .irq       (irq_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            ctx <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (in_valid_i) begin
                        if (refuse) begin
                            st  <= ST_DROP;
                            ctx <= '0;
                        end else begin
                            st  <= ST_DESC;
                            ctx <= '{group: group_i, stop: fd_susp_i | fd_eol_i,
                                     trunc: 1'b0, in_crc: 1'b0, keep_stat: 1'b1};
                        end
                    end
                end
                ST_DESC: begin
                    if (bd_valid_i) begin
                        if (!cap_zero) begin
                            st <= ST_MOVE;
                        end else if (bd_chain) begin
                            ctx.trunc <= 1'b1;
                            st        <= ctx.in_crc ? ST_DONE : ST_DROP;
                        end
                    end
                end
                ST_MOVE: begin
                    if (!ctx.in_crc) begin
                        if (in_valid_i) begin
                            if (in_last_i) ctx.in_crc <= 1'b1;
                            if (buf_full) begin
                                if (chain) begin
                                    ctx.trunc <= 1'b1;
                                    st        <= in_last_i ? ST_DONE : ST_DROP;
                                end else begin
                                    st <= ST_DESC;
                                end
                            end
                        end
                    end else if (crc_final) begin
                        st <= ST_DONE;
                    end else if (buf_full) begin
                        if (chain) begin
                            ctx.trunc <= 1'b1;
                            st        <= ST_DONE;
                        end else begin
                            st <= ST_DESC;
                        end
                    end
                end
                ST_DROP: begin
                    if (in_valid_i && in_last_i)
                        st <= ctx.keep_stat ? ST_DONE : ST_IDLE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_scatter_chk.sv
module rx_scatter_chk #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             cnt_we,
    input logic [CNT_W+1:0] cnt_word,
    input logic             stat_we,
    input logic [15:0]      stat_word,
    input logic             ovf,
    input logic             frame_ev,
    input logic             irq
);
    logic [CNT_W:0] bytes_since;
    logic           last_eof;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_since <= '0;
            last_eof    <= 1'b0;
        end else begin
            if (cnt_we)     bytes_since <= '0;
            else if (wr_en) bytes_since <= bytes_since + (CNT_W+1)'(1);
            if (cnt_we)       last_eof <= cnt_word[CNT_W+1];
            else if (stat_we) last_eof <= 1'b0;
        end
    end

    // R2: reported count equals the bytes written into that buffer
    p_count_len_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_we |-> ({1'b0, cnt_word[CNT_W-1:0]} == bytes_since + (CNT_W+1)'(wr_en)));

    // R9: a zero-capacity buffer writes nothing
    p_ovf_silent_r9: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (!wr_en && !cnt_we));

    // R6: interrupt follows a finished frame
    p_irq_follows_r6: assert property (@(posedge clk) disable iff (rst)
        frame_ev |=> irq);

    // R5: a good status needs an end-of-frame write-back before it
    p_ok_has_eof_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_we && stat_word[13]) |-> last_eof);

    // R3: end-of-frame write-back is followed by a good status
    p_eof_then_ok_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_we && cnt_word[CNT_W+1]) |=> (stat_we && stat_word[13]));

endmodule

bind rx_scatter rx_scatter_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en_o),
    .cnt_we    (cnt_we_o),
    .cnt_word  (cnt_word_o),
    .stat_we   (stat_we_o),
    .stat_word (stat_word_o),
    .ovf       (ovf_o),
    .frame_ev  (frame_ev_o),
    .irq       (irq_o)
);

// File: tb/test_rx_scatter.sv
module test_rx_scatter;
    localparam int CLK_P = 10;
    localparam int CNT_W = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up_i = 1'b1, ru_start_i = 1'b0, irq_ack_i = 1'b0;
    logic        in_valid_i = 1'b0, in_last_i = 1'b0;
    logic [7:0]  in_data_i = '0;
    logic [31:0] crc_i = '0;
    logic        group_i = 1'b0, fd_susp_i = 1'b0, fd_eol_i = 1'b0;
    logic        bd_valid_i = 1'b0;
    logic [15:0] bd_size_i = '0;
    logic        in_ready_o, bd_ready_o, wr_en_o, cnt_we_o, stat_we_o;
    logic [13:0] wr_addr_o;
    logic [7:0]  wr_data_o;
    logic [15:0] cnt_word_o, stat_word_o;
    logic        frame_ev_o, rnr_ev_o, ovf_o, irq_o;

    always #(CLK_P/2) clk = ~clk;

    rx_scatter #(.CNT_W(CNT_W), .CRC_BYTES(4)) i_rx_scatter (
        .clk(clk), .rst(rst), .link_up_i(link_up_i), .ru_start_i(ru_start_i),
        .irq_ack_i(irq_ack_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
        .in_data_i(in_data_i), .in_last_i(in_last_i), .crc_i(crc_i),
        .group_i(group_i), .fd_susp_i(fd_susp_i), .fd_eol_i(fd_eol_i),
        .bd_valid_i(bd_valid_i), .bd_ready_o(bd_ready_o), .bd_size_i(bd_size_i),
        .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .cnt_we_o(cnt_we_o), .cnt_word_o(cnt_word_o), .stat_we_o(stat_we_o),
        .stat_word_o(stat_word_o), .frame_ev_o(frame_ev_o), .rnr_ev_o(rnr_ev_o),
        .ovf_o(ovf_o), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // frame under test
    logic [7:0]  fb [0:63];
    int          fn;
    logic [31:0] fcrc;
    logic [15:0] bsz [0:7];
    int          bn;
    bit          gap_en;

    // expected
    logic [13:0] e_wa [0:255];
    logic [7:0]  e_wd [0:255];
    int          e_wn;
    logic [15:0] e_cw [0:15];
    int          e_cn;
    int          e_ovf;
    logic [15:0] e_stat;

    // observed
    logic [13:0] o_wa [0:255];
    logic [7:0]  o_wd [0:255];
    int          o_wn;
    logic [15:0] o_cw [0:15];
    int          o_cn;
    int          o_ovf, o_bdn, o_statn, mon_since;
    logic [15:0] o_stat;
    logic        o_rnr, o_fev, o_irq1, o_irq2;
    bit          done_flag;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en_o && o_wn < 256) begin
                o_wa[o_wn] = wr_addr_o; o_wd[o_wn] = wr_data_o; o_wn++;
            end
            if (cnt_we_o && o_cn < 16) begin
                o_cw[o_cn] = cnt_word_o; o_cn++;
            end
            if (ovf_o) o_ovf++;
            if (bd_valid_i && bd_ready_o) o_bdn++;
            if (stat_we_o) begin
                o_stat = stat_word_o; o_statn++; o_rnr = rnr_ev_o; o_fev = frame_ev_o;
                mon_since = 1; done_flag = 1'b1;
            end else if (mon_since == 1) begin
                o_irq1 = irq_o; mon_since = 2;
            end else if (mon_since == 2) begin
                o_irq2 = irq_o; mon_since = 0;
            end
        end
    end

    function automatic logic [7:0] stream_byte(input int s);
        if (s < fn) return fb[s];
        return 8'(fcrc >> (8 * (3 - (s - fn))));
    endfunction

    task automatic build_expect(input bit grp);
        int rem, s, cap, take;
        bit ok;
        e_wn = 0; e_cn = 0; e_ovf = 0; rem = fn + 4; s = 0; ok = 1'b0;
        for (int b = 0; b < bn; b++) begin
            cap = int'(bsz[b][13:0]);
            if (cap == 0) begin
                e_ovf++;
                if (bsz[b][15]) break;
                continue;
            end
            take = (cap < rem) ? cap : rem;
            for (int k = 0; k < take; k++) begin
                e_wa[e_wn] = 14'(k); e_wd[e_wn] = stream_byte(s); e_wn++; s++;
            end
            rem = rem - take;
            e_cw[e_cn] = 16'h4000 | 16'(take) | ((rem == 0) ? 16'h8000 : 16'h0000);
            e_cn++;
            if (rem == 0) begin ok = 1'b1; break; end
            if (bsz[b][15]) break;
        end
        e_stat = 16'h8000 | (ok ? 16'h2000 : 16'h0000) | 16'(grp);
    endtask

    task automatic send_bytes();
        int i;
        i = 0;
        while (i < fn) begin
            @(posedge clk); #1;
            in_valid_i = !(gap_en && ($urandom % 4 == 0));
            in_data_i  = fb[i];
            in_last_i  = (i == fn - 1);
            @(negedge clk);
            if (in_valid_i && in_ready_o) i++;
        end
        @(posedge clk); #1;
        in_valid_i = 1'b0; in_last_i = 1'b0;
    endtask

    task automatic feed_bds();
        int i;
        i = 0;
        while (!done_flag) begin
            @(posedge clk); #1;
            bd_valid_i = (i < bn);
            bd_size_i  = (i < bn) ? bsz[i] : 16'h0;
            @(negedge clk);
            if (bd_valid_i && bd_ready_o) i++;
        end
        @(posedge clk); #1;
        bd_valid_i = 1'b0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1; ru_start_i = 1'b1;
        @(posedge clk); #1; ru_start_i = 1'b0;
    endtask

    task automatic run_frame(input string tag, input bit grp, input bit susp,
                             input bit eol, input bit accept, input bit ack_hold);
        o_wn = 0; o_cn = 0; o_ovf = 0; o_bdn = 0; o_statn = 0; mon_since = 0;
        o_rnr = 1'b0; o_fev = 1'b0; o_irq1 = 1'b0; o_irq2 = 1'b0; done_flag = 1'b0;
        @(posedge clk); #1;
        group_i = grp; fd_susp_i = susp; fd_eol_i = eol; crc_i = fcrc; irq_ack_i = ack_hold;
        if (accept) begin
            build_expect(grp);
            fork
                send_bytes();
                feed_bds();
            join
        end else begin
            bd_valid_i = 1'b1; bd_size_i = 16'h800a;
            send_bytes();
            repeat (4) @(negedge clk);
            bd_valid_i = 1'b0;
        end
        repeat (3) @(negedge clk);
        if (accept) begin
            check(o_wn == e_wn, "R1", {tag, " byte count"}, o_wn, e_wn);
            for (int i = 0; i < e_wn && i < o_wn; i++) begin
                check(o_wa[i] == e_wa[i], "R1", {tag, " addr"}, o_wa[i], e_wa[i]);
                check(o_wd[i] == e_wd[i], "R1", {tag, " data"}, o_wd[i], e_wd[i]);
            end
            check(o_cn == e_cn, "R2", {tag, " count writes"}, o_cn, e_cn);
            for (int i = 0; i < e_cn && i < o_cn; i++)
                check(o_cw[i] == e_cw[i], "R3", {tag, " count word"}, o_cw[i], e_cw[i]);
            check(o_ovf == e_ovf, "R9", {tag, " overflow"}, o_ovf, e_ovf);
            check(o_statn == 1 && o_stat == e_stat, "R5", {tag, " status"}, o_stat, e_stat);
            check(o_fev == 1'b1, "R5", {tag, " frame event"}, o_fev, 1);
            check(o_rnr == (susp | eol), "R8", {tag, " left-active event"}, o_rnr, susp | eol);
            check(o_irq1 == 1'b1, "R6", {tag, " irq after status"}, o_irq1, 1);
            check(o_irq2 == !ack_hold, "R6", {tag, " irq next cycle"}, o_irq2, !ack_hold);
            @(posedge clk); #1; irq_ack_i = 1'b1;
            @(posedge clk); #1; irq_ack_i = 1'b0;
            @(negedge clk);
            check(irq_o == 1'b0, "R6", {tag, " irq cleared"}, irq_o, 0);
        end else begin
            check(o_wn == 0 && o_cn == 0, "R7", {tag, " no writes"}, o_wn + o_cn, 0);
            check(o_statn == 0, "R7", {tag, " no status"}, o_statn, 0);
            check(o_bdn == 0, "R7", {tag, " no descriptor"}, o_bdn, 0);
        end
    endtask

    task automatic fill_data(input int n);
        fn = n;
        for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
        fcrc = $urandom;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        gap_en = 1'b0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(in_ready_o == 0 && bd_ready_o == 0, "R10", "ready in reset", {in_ready_o, bd_ready_o}, 0);
        check(wr_en_o == 0 && cnt_we_o == 0 && stat_we_o == 0, "R10", "writes in reset",
              {wr_en_o, cnt_we_o, stat_we_o}, 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(irq_o == 0 && in_ready_o == 0 && bd_ready_o == 0, "R10", "after reset",
              {irq_o, in_ready_o, bd_ready_o}, 0);

        // R7/R8: unit is suspended after reset, frame refused
        fill_data(5); bn = 1; bsz[0] = 16'h800a;
        run_frame("suspended-after-reset", 0, 0, 0, 0, 0);
        pulse_start();

        // R3: check bytes straddle two buffers
        fill_data(6); bn = 2; bsz[0] = 16'd8; bsz[1] = 16'h800a;
        run_frame("crc-straddle", 1, 0, 0, 1, 0);

        // R3/R6: check bytes fill a buffer exactly, acknowledge held at completion
        fill_data(4); bn = 1; bsz[0] = 16'h8008;
        run_frame("exact-fill-ack", 0, 0, 0, 1, 1);

        // R9: zero-capacity buffer skipped
        fill_data(5); bn = 2; bsz[0] = 16'h0000; bsz[1] = 16'h800c;
        run_frame("zero-cap", 0, 0, 0, 1, 0);

        // R2: bit 14 of the size word is not capacity or chain end
        fill_data(5); bn = 2; bsz[0] = 16'h4006; bsz[1] = 16'h800a;
        run_frame("fill-bit-ignored", 1, 0, 0, 1, 0);

        // R4: chain ends before the frame does
        gap_en = 1'b1;
        fill_data(20); bn = 1; bsz[0] = 16'h8008;
        run_frame("truncated", 1, 0, 0, 1, 0);

        // R4/R9: zero-capacity chain end while data is still owed
        fill_data(7); bn = 2; bsz[0] = 16'd5; bsz[1] = 16'h8000;
        run_frame("zero-chain-end", 0, 0, 0, 1, 0);
        gap_en = 1'b0;

        // R8: suspend flag, then refused frame, then end-of-list flag
        fill_data(3); bn = 1; bsz[0] = 16'h8010;
        run_frame("suspend-flag", 0, 1, 0, 1, 0);
        fill_data(3);
        run_frame("refused-after-suspend", 0, 0, 0, 0, 0);
        pulse_start();
        fill_data(3);
        run_frame("eol-flag", 1, 0, 1, 1, 0);
        pulse_start();

        // R7: link down
        @(posedge clk); #1; link_up_i = 1'b0;
        fill_data(4);
        run_frame("link-down", 0, 0, 0, 0, 0);
        @(posedge clk); #1; link_up_i = 1'b1;

        // random frames
        for (int f = 0; f < 30; f++) begin
            bit s, e;
            gap_en = ($urandom % 2) == 1;
            fill_data(1 + int'($urandom % 40));
            bn = 1 + int'($urandom % 6);
            for (int b = 0; b < bn; b++) begin
                bsz[b] = ($urandom % 8 == 0) ? 16'h0 : 16'(1 + $urandom % 20);
                if (b == bn - 1) bsz[b][15] = 1'b1;
            end
            s = ($urandom % 5) == 0;
            e = ($urandom % 6) == 0;
            run_frame("random", 1'($urandom), s, e, 1, 0);
            pulse_start();
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule